// File: doc/BRIEF.md
# Hashed page table walker

This block resolves a virtual-to-real translation after a translation cache miss. The effective address picks one of sixteen segment registers, which supplies the virtual segment ID, the two protection-key bits and the no-execute bit. From the segment ID and the page index the walker forms a primary hash and its bitwise inverse, the secondary hash. Each hash selects a group of page table entries in memory.

The walker reads the entries of a group one 32-bit word at a time over a valid/ready request port. It compares each entry against the tag it expects and evaluates the protection bits for the access. It keeps the referenced and changed flags of the chosen entry up to date in memory. Only one walk is in flight at a time. A one-cycle `done_o` pulse reports the status, the real page number and the granted permissions.

Top module: `hpt_walker`

## Requirements
- R1: The segment register is `seg_regs_i[32*k +: 32]` with k = `ea_i[31:28]`. Its VSID is bits 23:0, Ks is bit 30, Kp is bit 29 and N is bit 28. The access key is 1 when (Kp=1 and `user_i`=1) or (Ks=1 and `user_i`=0), and 0 otherwise.
- R2: The page index is `ea_i[27:12]`. The primary hash is VSID XOR page index and the secondary hash is its 24-bit inverse. The group address is `table_base_i | ((hash << 6) & table_mask_i)`. Entry i has word 0 at group+8i and word 1 at group+8i+4.
- R3: An entry matches only if all of the following hold: word 0 bit 31 (valid) is 1, bit 6 (H) equals the group being searched (0 primary, 1 secondary), bits 30:7 equal the VSID, and bits 5:0 equal page index bits 15:10.
- R4: Permissions are returned as bit 0 read, bit 1 write, bit 2 execute. The PP field is word 1 bits 1:0. With key 0, PP 0 to 2 give read and write and PP 3 gives read only. With key 1, PP 0 gives nothing, PP 1 and PP 3 give read, and PP 2 gives read and write. Execute is given unless the segment N bit is set.
- R5: A fetch needs execute, a store needs write and a load needs read. The first match that passes ends the search of its group. A failing match is remembered and the scan goes on.
- R6: If a later match in the same group differs from the remembered match in word 1 bits 31:12, 6:3 or 1:0, the walk ends as a miss with no write-back.
- R7: The secondary group is searched only when the primary group gives no passing match. The result of the secondary group is used unless that group is a plain miss. In that case a protection failure from the primary group is reported.
- R8: For the chosen entry, the referenced bit (word 1 bit 8) is set if it is clear. The changed bit (bit 7) is set only on a store that passes. If the changed bit stays clear, write is removed from the returned permissions. Word 1 is written back only when its value changes.
- R9: A fetch to a segment with N=1 ends with status 3 and makes no memory request.
- R10: `done_o` pulses for one cycle with the status: 0 hit, 1 miss, 2 protection violation, 3 no-execute. `rpn_o` is word 1 bits 31:12 of the entry reported. On a miss, `rpn_o` and `perm_o` are zero.
- R11: A request holds valid, address, write flag and data until ready. Each accepted read gets exactly one `mrsp_valid_i` beat. Writes get no response. No request is made while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start_i | input | 1 | begin a walk (accepted when idle) |
| ea_i | input | 32 | effective address |
| store_i | input | 1 | access is a store |
| fetch_i | input | 1 | access is an instruction fetch |
| user_i | input | 1 | access is from user state |
| seg_regs_i | input | 512 | sixteen segment registers, register k in bits 32k+31:32k |
| table_base_i | input | 32 | page table base address |
| table_mask_i | input | 32 | page table group offset mask |
| mreq_valid_o | output | 1 | memory request valid |
| mreq_ready_i | input | 1 | memory request accepted |
| mreq_write_o | output | 1 | request is a write |
| mreq_addr_o | output | 32 | byte address of the word |
| mreq_wdata_o | output | 32 | write data |
| mrsp_valid_i | input | 1 | read data valid |
| mrsp_data_i | input | 32 | read data |
| busy_o | output | 1 | a walk is in progress |
| done_o | output | 1 | one-cycle result pulse |
| status_o | output | 2 | result status code |
| rpn_o | output | 20 | real page number |
| perm_o | output | 3 | granted permissions |

## Verification
The bench builds the walker with the default eight entries per group and drives a table mask of 0x3FC0, so 256 groups fit in a 16 KB bench memory. Primary and secondary groups then lie in distinct and predictable places. This lets the scenarios place chosen entries in a group: entries with the wrong H bit, protection failures followed by passing or conflicting matches, and two consistent matches where only the first may be written back. The memory throttles ready on a fixed pattern, so held requests are exercised on every walk.

// File: rtl/hptw_pkg.sv
package hptw_pkg;
  typedef enum logic [1:0] {
    ST_HIT  = 2'd0,
    ST_MISS = 2'd1,
    ST_PROT = 2'd2,
    ST_NX   = 2'd3
  } walk_status_e;

  localparam int VSID_W = 24;
  localparam int PIDX_W = 16;
  localparam int API_W  = 6;
  // word 1 fields that all matches of one group must agree on
  localparam logic [31:0] CONSIST_MASK = 32'hFFFF_F07B;
  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;
endpackage

// File: rtl/hptw_hash.sv
module hptw_hash
  import hptw_pkg::*;
(
  input  logic [31:0]       ea,
  input  logic [31:0]       sreg,
  input  logic              user,
  output logic              key,
  output logic              no_exec,
  output logic [VSID_W-1:0] vsid,
  output logic [VSID_W-1:0] hash_pri,
  output logic [API_W-1:0]  api
);
  logic [PIDX_W-1:0] pidx;

  always_comb begin
    pidx     = ea[27:12];
    vsid     = sreg[VSID_W-1:0];
    key      = (sreg[29] & user) | (sreg[30] & ~user);
    no_exec  = sreg[28];
    hash_pri = vsid ^ VSID_W'(pidx);
    api      = pidx[PIDX_W-1 -: API_W];
  end
endmodule

// File: rtl/hptw_prot.sv
module hptw_prot (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       no_exec,
  input  logic       is_store,
  input  logic       is_fetch,
  output logic [2:0] perm,
  output logic       granted
);
  logic rd, wr;

  always_comb begin
    if (!key) begin
      rd = 1'b1;
      wr = (pp != 2'd3);
    end else begin
      rd = (pp != 2'd0);
      wr = (pp == 2'd2);
    end
    perm = {~no_exec, wr, rd};
    if (is_fetch)      granted = perm[2];
    else if (is_store) granted = perm[1];
    else               granted = perm[0];
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hptw_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [31:0]  ea_i,
  input  logic         store_i,
  input  logic         fetch_i,
  input  logic         user_i,
  input  logic [511:0] seg_regs_i,
  input  logic [31:0]  table_base_i,
  input  logic [31:0]  table_mask_i,
  output logic         mreq_valid_o,
  input  logic         mreq_ready_i,
  output logic         mreq_write_o,
  output logic [31:0]  mreq_addr_o,
  output logic [31:0]  mreq_wdata_o,
  input  logic         mrsp_valid_i,
  input  logic [31:0]  mrsp_data_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [1:0]   status_o,
  output logic [19:0]  rpn_o,
  output logic [2:0]   perm_o
);
  localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int GRP_SH = $clog2(N_ENT) + 3;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_WT0, S_RD1, S_WT1, S_EVAL, S_FLAGS, S_WB, S_RES
  } state_e;

  state_e           state;
  logic [31:0]      ea_q, sreg_q, base_q, mask_q;
  logic             st_q, fe_q, us_q;
  logic             h_q;
  logic [IDX_W-1:0] idx_q, midx_q;
  logic [31:0]      w0_q, w1_q, mw1_q, wb_q;
  logic [2:0]       mperm_q, fperm_q;
  logic             hav_q, grant_q;
  logic             pv_q;
  logic [19:0]      p_rpn_q;
  logic [2:0]       p_perm_q;
  logic             done_q;
  logic [1:0]       status_q;
  logic [19:0]      rpn_q;
  logic [2:0]       perm_q;

  // segment selected straight from the request, for the no-execute decision
  logic [31:0] sreg_in;
  assign sreg_in = seg_regs_i[32*ea_i[31:28] +: 32];

  logic              key, nx;
  logic [VSID_W-1:0] vsid, hash_pri, hash_sel;
  logic [API_W-1:0]  api;

  hptw_hash u_hash (
    .ea(ea_q), .sreg(sreg_q), .user(us_q),
    .key(key), .no_exec(nx), .vsid(vsid), .hash_pri(hash_pri), .api(api)
  );

  logic [2:0] eperm;
  logic       egrant;

  hptw_prot u_prot (
    .key(key), .pp(w1_q[1:0]), .no_exec(nx),
    .is_store(st_q), .is_fetch(fe_q), .perm(eperm), .granted(egrant)
  );

  logic [31:0] grp_addr, ent_addr;
  logic        match, conflict;
  logic [31:0] new_w1;
  logic [2:0]  new_perm;

  always_comb begin
    hash_sel = h_q ? ~hash_pri : hash_pri;
    grp_addr = base_q | ((32'(hash_sel) << GRP_SH) & mask_q);
    ent_addr = grp_addr + (32'(idx_q) << 3);
    match    = w0_q[31] && (w0_q[6] == h_q) && (w0_q[30:7] == vsid) &&
               (w0_q[5:0] == api);
    conflict = hav_q && (((w1_q ^ mw1_q) & CONSIST_MASK) != 32'd0);
    new_w1   = mw1_q;
    new_perm = mperm_q;
    new_w1[REF_BIT] = 1'b1;
    if (!mw1_q[CHG_BIT]) begin
      if (grant_q && st_q && !fe_q) new_w1[CHG_BIT] = 1'b1;
      else                          new_perm[1]     = 1'b0;
    end
  end

  always_comb begin
    mreq_valid_o = (state == S_RD0) || (state == S_RD1) || (state == S_WB);
    mreq_write_o = (state == S_WB);
    mreq_wdata_o = wb_q;
    case (state)
      S_RD1:   mreq_addr_o = ent_addr + 32'd4;
      S_WB:    mreq_addr_o = grp_addr + (32'(midx_q) << 3) + 32'd4;
      default: mreq_addr_o = ent_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      ea_q     <= '0; sreg_q <= '0; base_q <= '0; mask_q <= '0;
      st_q     <= 1'b0; fe_q <= 1'b0; us_q <= 1'b0;
      h_q      <= 1'b0; idx_q <= '0; midx_q <= '0;
      w0_q     <= '0; w1_q <= '0; mw1_q <= '0; wb_q <= '0;
      mperm_q  <= '0; fperm_q <= '0;
      hav_q    <= 1'b0; grant_q <= 1'b0;
      pv_q     <= 1'b0; p_rpn_q <= '0; p_perm_q <= '0;
      done_q   <= 1'b0; status_q <= ST_MISS; rpn_q <= '0; perm_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          ea_q   <= ea_i;   sreg_q <= sreg_in;
          base_q <= table_base_i; mask_q <= table_mask_i;
          st_q   <= store_i; fe_q <= fetch_i; us_q <= user_i;
          h_q    <= 1'b0; idx_q <= '0; hav_q <= 1'b0; pv_q <= 1'b0;
          if (fetch_i && sreg_in[28]) begin
            done_q <= 1'b1; status_q <= ST_NX; rpn_q <= '0; perm_q <= '0;
          end else begin
            state <= S_RD0;
          end
        end
        S_RD0: if (mreq_ready_i) state <= S_WT0;
        S_WT0: if (mrsp_valid_i) begin w0_q <= mrsp_data_i; state <= S_RD1; end
        S_RD1: if (mreq_ready_i) state <= S_WT1;
        S_WT1: if (mrsp_valid_i) begin w1_q <= mrsp_data_i; state <= S_EVAL; end
        S_EVAL: begin
          if (match && conflict) begin
            done_q <= 1'b1; status_q <= ST_MISS; rpn_q <= '0; perm_q <= '0;
            state  <= S_IDLE;
          end else if (match && egrant) begin
            mw1_q <= w1_q; midx_q <= idx_q; mperm_q <= eperm;
            grant_q <= 1'b1; state <= S_FLAGS;
          end else begin
            if (match) begin
              mw1_q <= w1_q; midx_q <= idx_q; mperm_q <= eperm; hav_q <= 1'b1;
            end
            if (idx_q != LAST_IDX) begin
              idx_q <= idx_q + 1'b1; state <= S_RD0;
            end else if (hav_q || match) begin
              grant_q <= 1'b0; state <= S_FLAGS;
            end else if (!h_q) begin
              h_q <= 1'b1; idx_q <= '0; hav_q <= 1'b0; state <= S_RD0;
            end else begin
              done_q   <= 1'b1;
              status_q <= pv_q ? ST_PROT : ST_MISS;
              rpn_q    <= pv_q ? p_rpn_q : '0;
              perm_q   <= pv_q ? p_perm_q : '0;
              state    <= S_IDLE;
            end
          end
        end
        S_FLAGS: begin
          fperm_q <= new_perm;
          wb_q    <= new_w1;
          state   <= (new_w1 != mw1_q) ? S_WB : S_RES;
        end
        S_WB: if (mreq_ready_i) state <= S_RES;
        S_RES: begin
          if (grant_q || h_q) begin
            done_q   <= 1'b1;
            status_q <= grant_q ? ST_HIT : ST_PROT;
            rpn_q    <= mw1_q[31:12];
            perm_q   <= fperm_q;
            state    <= S_IDLE;
          end else begin
            pv_q <= 1'b1; p_rpn_q <= mw1_q[31:12]; p_perm_q <= fperm_q;
            h_q  <= 1'b1; idx_q <= '0; hav_q <= 1'b0; state <= S_RD0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state != S_IDLE);
  assign done_o   = done_q;
  assign status_o = status_q;
  assign rpn_o    = rpn_q;
  assign perm_o   = perm_q;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    mreq_valid_o && !mreq_ready_i |=> mreq_valid_o && $stable(mreq_addr_o) &&
                                      $stable(mreq_write_o));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mreq_valid_o);
  p_wb_ref_r8: assert property (@(posedge clk) disable iff (rst)
    mreq_valid_o && mreq_write_o |-> mreq_wdata_o[REF_BIT]);
  p_miss_zero_r10: assert property (@(posedge clk) disable iff (rst)
    done_o && status_o == ST_MISS |-> rpn_o == 20'd0 && perm_o == 3'd0);
  p_nx_direct_r9: assert property (@(posedge clk) disable iff (rst)
    done_o && status_o == ST_NX |-> $past(!busy_o));
  p_hit_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    done_o && status_o == ST_HIT |-> perm_o != 3'd0);
endmodule

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         start, store, fetch, user;
  logic [31:0]  ea;
  logic [31:0]  segs [16];
  logic [511:0] seg_flat;
  logic         mreq_valid, mreq_ready, mreq_write, mrsp_valid;
  logic [31:0]  mreq_addr, mreq_wdata, mrsp_data;
  logic         busy, done;
  logic [1:0]   status;
  logic [19:0]  rpn;
  logic [2:0]   perm;

  localparam logic [31:0] TBASE = 32'h0;
  localparam logic [31:0] TMASK = 32'h0000_3FC0;

  always_comb for (int k = 0; k < 16; k++) seg_flat[32*k +: 32] = segs[k];

  hpt_walker i_hpt_walker (
    .clk(clk), .rst(rst), .start_i(start), .ea_i(ea), .store_i(store),
    .fetch_i(fetch), .user_i(user), .seg_regs_i(seg_flat),
    .table_base_i(TBASE), .table_mask_i(TMASK),
    .mreq_valid_o(mreq_valid), .mreq_ready_i(mreq_ready),
    .mreq_write_o(mreq_write), .mreq_addr_o(mreq_addr),
    .mreq_wdata_o(mreq_wdata), .mrsp_valid_i(mrsp_valid),
    .mrsp_data_i(mrsp_data), .busy_o(busy), .done_o(done),
    .status_o(status), .rpn_o(rpn), .perm_o(perm)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] mem [4096];
  logic [31:0] rmem [4096];
  logic [63:0] exp_wr [$];
  bit req_seen;

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model: ready on a fixed throttle, read data one cycle after accept
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mrsp_valid <= 1'b0;
    mreq_ready <= (cyc % 4) != 3;
    if (rst) mreq_ready <= 1'b0;
    else if (mreq_valid && mreq_ready) begin
      req_seen <= 1'b1;
      if (mreq_write) begin
        mem[mreq_addr[13:2]] <= mreq_wdata;
        checks++;
        if (exp_wr.size() == 0 || exp_wr[0] != {mreq_addr, mreq_wdata}) begin
          errors++;
          $display("FAIL R8 write actual=%h expected=%h", {mreq_addr, mreq_wdata},
                   (exp_wr.size() != 0) ? exp_wr[0] : 64'h0);
        end
        if (exp_wr.size() != 0) void'(exp_wr.pop_front());
      end else begin
        mrsp_valid <= 1'b1;
        mrsp_data  <= mem[mreq_addr[13:2]];
      end
    end
  end

  // every clock: an idle walker must keep the request port quiet (R11)
  always @(negedge clk) begin
    if (!rst && !busy && mreq_valid) begin
      errors++;
      $display("FAIL R11 idle request actual=1 expected=0");
    end
  end

  function automatic logic [31:0] gaddr(logic [23:0] vsid, logic [15:0] pg, bit h);
    logic [23:0] hs;
    hs = vsid ^ {8'h0, pg};
    if (h) hs = ~hs;
    return TBASE | (({8'h0, hs} << 6) & TMASK);
  endfunction

  task automatic put(logic [23:0] vsid, logic [15:0] pg, bit h, bit hfield,
                     int slot, logic [31:0] w1);
    logic [31:0] a, w0;
    a  = gaddr(vsid, pg, h) + slot * 8;
    w0 = {1'b1, vsid, hfield, pg[15:10]};
    mem[a[13:2]] = w0; rmem[a[13:2]] = w0;
    mem[a[13:2] + 1] = w1; rmem[a[13:2] + 1] = w1;
  endtask

  // reference: search one group; code 0 pass, 1 none, 2 protection, 3 conflict
  task automatic ref_group(logic [23:0] vsid, logic [15:0] pg, bit h, bit key, bit n,
                           bit st, bit fe, output int code, output logic [19:0] o_rpn,
                           output logic [2:0] o_perm);
    logic [31:0] ga, w0, w1, mw1;
    int midx;
    bit have, rd, wr, ok;
    logic [2:0] pm, mpm;
    ga = gaddr(vsid, pg, h);
    have = 0; code = 1; midx = 0; mw1 = 0; mpm = 0;
    for (int i = 0; i < 8; i++) begin
      w0 = rmem[(ga >> 2) + 2 * i];
      w1 = rmem[(ga >> 2) + 2 * i + 1];
      if (w0[31] && w0[6] == h && w0[30:7] == vsid && w0[5:0] == pg[15:10]) begin
        if (have && ((w1 & 32'hFFFF_F07B) != (mw1 & 32'hFFFF_F07B))) begin
          code = 3; o_rpn = 0; o_perm = 0; return;
        end
        rd = key ? (w1[1:0] != 0) : 1'b1;
        wr = key ? (w1[1:0] == 2) : (w1[1:0] != 3);
        pm = {!n, wr, rd};
        ok = fe ? pm[2] : (st ? pm[1] : pm[0]);
        have = 1; mw1 = w1; midx = i; mpm = pm;
        if (ok) begin code = 0; break; end
        code = 2;
      end
    end
    o_rpn = mw1[31:12]; o_perm = mpm;
    if (code == 0 || code == 2) begin
      w1 = mw1 | 32'h100;
      if (!mw1[7]) begin
        if (code == 0 && st && !fe) w1 = w1 | 32'h80;
        else o_perm[1] = 1'b0;
      end
      if (w1 != mw1) begin
        exp_wr.push_back({ga + midx * 8 + 4, w1});
        rmem[(ga >> 2) + 2 * midx + 1] = w1;
      end
    end
  endtask

  task automatic ref_walk(logic [31:0] a, bit st, bit fe, bit us, output logic [1:0] e_st,
                          output logic [19:0] e_rpn, output logic [2:0] e_perm);
    logic [31:0] sr;
    bit key, n;
    int c0, c1;
    logic [19:0] r0, r1;
    logic [2:0] p0, p1;
    sr  = segs[a[31:28]];
    key = (us && sr[29]) || (!us && sr[30]);
    n   = sr[28];
    e_rpn = 0; e_perm = 0;
    if (fe && n) begin e_st = 3; return; end
    ref_group(sr[23:0], a[27:12], 0, key, n, st, fe, c0, r0, p0);
    if (c0 == 0) begin e_st = 0; e_rpn = r0; e_perm = p0; return; end
    if (c0 == 3) begin e_st = 1; return; end
    ref_group(sr[23:0], a[27:12], 1, key, n, st, fe, c1, r1, p1);
    if (c1 == 0) begin e_st = 0; e_rpn = r1; e_perm = p1; end
    else if (c1 == 2) begin e_st = 2; e_rpn = r1; e_perm = p1; end
    else if (c1 == 1 && c0 == 2) begin e_st = 2; e_rpn = r0; e_perm = p0; end
    else e_st = 1;
  endtask

  task automatic run(logic [31:0] a, bit st, bit fe, bit us, string rq);
    logic [1:0] e_st;
    logic [19:0] e_rpn;
    logic [2:0] e_perm;
    int waitc;
    ref_walk(a, st, fe, us, e_st, e_rpn, e_perm);
    @(negedge clk);
    req_seen = 0;
    ea = a; store = st; fetch = fe; user = us; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitc = 0;
    while (!done && waitc < 2000) begin
      if (waitc == 0 && e_st != 3 && !busy) break;
      @(negedge clk); waitc++;
    end
    chk(done === 1'b1, {rq, " done"}, 32'(done), 1);
    chk(status === e_st, {rq, " status R10"}, 32'(status), 32'(e_st));
    chk(rpn === e_rpn, {rq, " rpn R10"}, 32'(rpn), 32'(e_rpn));
    chk(perm === e_perm, {rq, " perm R4"}, 32'(perm), 32'(e_perm));
    @(negedge clk);
    chk(done === 1'b0, {rq, " single pulse R10"}, 32'(done), 0);
    chk(exp_wr.size() == 0, {rq, " pending writes R8"}, 32'(exp_wr.size()), 0);
    if (e_st == 3) chk(!req_seen, {rq, " no access R9"}, 32'(req_seen), 0);
  endtask

  initial begin
    start = 0; ea = 0; store = 0; fetch = 0; user = 0; req_seen = 0;
    mrsp_data = 0;
    for (int i = 0; i < 4096; i++) begin mem[i] = 0; rmem[i] = 0; end
    for (int k = 0; k < 16; k++) segs[k] = 32'h0;
    segs[1] = 32'h2000_0123;          // Kp only
    segs[2] = 32'h5000_04A5;          // Ks and N
    segs[3] = 32'h6000_ABCD;          // Ks and Kp
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !busy && !mreq_valid, "reset R10", {done, busy, mreq_valid}, 0);

    put(24'h123, 16'h0010, 0, 0, 3, 32'h0005_5002);
    run(32'h1001_0000, 0, 0, 0, "R2 R8 load sets ref, write withheld");
    run(32'h1001_0000, 1, 0, 0, "R8 store sets changed");
    run(32'h1001_0000, 0, 0, 0, "R8 no write when unchanged");

    put(24'h123, 16'h0020, 0, 1, 1, 32'h0006_6002);   // wrong H in primary
    put(24'h123, 16'h0020, 1, 1, 0, 32'h0007_7102);
    run(32'h1002_0000, 0, 0, 0, "R3 R7 secondary hit");

    put(24'h123, 16'h0030, 0, 0, 5, 32'h0008_8000);
    run(32'h1003_0000, 0, 0, 1, "R1 R5 user key1 pp0 protection");

    put(24'h123, 16'h0040, 0, 0, 2, 32'h0009_9000);
    put(24'h123, 16'h0040, 1, 1, 6, 32'h000A_A001);
    run(32'h1004_0000, 0, 0, 1, "R7 primary prot then secondary pass");

    put(24'h123, 16'h0050, 0, 0, 1, 32'h000B_B003);
    put(24'h123, 16'h0050, 0, 0, 4, 32'h000C_C003);
    run(32'h1005_0000, 1, 0, 1, "R6 conflicting matches miss");

    run(32'h1006_0000, 0, 0, 0, "R7 miss in both groups");
    run(32'h2000_7000, 0, 1, 0, "R9 no-execute fetch");

    put(24'h4A5, 16'h0007, 0, 0, 0, 32'h000D_D182);
    run(32'h2000_7000, 0, 0, 0, "R4 N segment load no execute");

    put(24'hABCD, 16'h0100, 0, 0, 7, 32'h000E_E001);
    run(32'h3010_0000, 0, 1, 0, "R1 R4 fetch key1 pp1");
    put(24'hABCD, 16'h0110, 0, 0, 0, 32'h000F_F000);
    run(32'h3011_0000, 0, 1, 0, "R5 fetch needs only execute");

    put(24'h123, 16'h0070, 0, 0, 2, 32'h0011_1001);
    put(24'h123, 16'h0070, 0, 0, 6, 32'h0011_1001);
    run(32'h1007_0000, 0, 0, 0, "R5 R11 first pass ends search");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule